// File: doc/BRIEF.md
# Quad Wiper Serial Control Port

This block is the digital control side of a four-channel digital potentiometer. It holds four 6-bit wiper position registers and exposes them as parallel outputs. A host loads or reads the registers through a slow five-signal serial port. The port has an enable strobe, a serial clock, a data input, a read/write select and a cascade data output. All serial inputs are asynchronous to the system clock. They are brought in through two-flop synchronizers, and their edges are found on the synchronized copies. The system clock must run at least four times faster than the serial clock.

Every serial word is 8 bits long and is shifted most significant bit first. The top two bits name a pot and the low six bits give its position. Because of this, one write transaction can carry one to four words, in any pot order. In read mode the port streams pot 0, 1, 2 and 3 in turn as full words, and then wraps back to pot 0. When the port is idle, the cascade output passes the data input through so that several devices can be chained.

A three-state controller runs the port. IDLE goes to WRITE or READ on a rising enable edge; the read/write select captured at that instant chooses which. WRITE and READ each return to IDLE on a falling enable edge. There are no other transitions.

Top module: `quad_wiper_port`

## Requirements
- R1: After reset all four wiper registers hold 32, the middle of the 0 (low end) to 63 (high end) range.
- R2: A written word uses bits 7:6 as the pot index (0 to 3) and bits 5:0 as the new position. The word is received MSB first, one bit per rising serial clock edge, and only the addressed register changes.
- R3: A word is committed on the falling edge of the eighth serial clock pulse. After the eighth rising edge and before that falling edge, the register still holds its old value.
- R4: The read/write select is captured on the rising edge of the enable. Toggling it during a transaction changes neither the mode nor the data.
- R5: One write transaction may carry several words back to back, addressing the pots in any order, and each word is committed on its own.
- R6: If the enable falls before a word is complete, the partial bits are dropped, no register changes, and the next transaction starts from bit 0.
- R7: While the port is idle, the cascade output equals the data input.
- R8: While a write transaction is active, the cascade output is held at 0.
- R9: In read mode each pot is sent as the 8-bit word {index, position}, MSB first. The first bit is present once the port opens, each further bit follows a falling serial clock edge, and the pots come in the order 0, 1, 2, 3.
- R10: After pot 3 has been sent, readback continues with pot 0.
- R11: Every commit pulses the load strobe high for exactly one system clock cycle, with the index of the pot just written on the load index output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en_i | input | 1 | Serial transaction enable (active high) |
| port_clk_i | input | 1 | Serial clock |
| port_din_i | input | 1 | Serial data input |
| port_rd_i | input | 1 | Read (1) / write (0) select |
| port_dout_o | output | 1 | Cascade / readback data output |
| wiper_o | output | 24 | Four wiper positions, pot n in bits 6n+5:6n |
| load_stb_o | output | 1 | One-cycle pulse on each register commit |
| load_idx_o | output | 2 | Index of the pot just committed |

## Verification
A table of single-word write transactions drives values to each pot, including the ends 0 and 63 and repeated writes to the same pot. Comparing all four outputs after each word separates correct pot decoding from writes that leak into a neighbouring register. A four-word transaction in reverse pot order shows that each word is committed on its own. A transaction cut off after five bits, followed by a full word, shows that the bit counter is cleared. A probe between the eighth rising and falling serial edges pins down the commit instant. Readback of five words, with distinct values in each pot, checks the index bits, the pot order and the wrap. Toggling the read/write select inside both kinds of transaction shows that the mode is frozen.

// File: rtl/qwp_pkg.sv
package qwp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } port_state_e;

endpackage

// File: rtl/qwp_sync.sv
module qwp_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/qwp_bank.sv
module qwp_bank #(
    parameter int NPOT = 4,
    parameter int PW   = 6,
    localparam int IDXW = $clog2(NPOT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [IDXW-1:0]    wr_idx_i,
    input  logic [PW-1:0]      wr_data_i,
    input  logic [IDXW-1:0]    rd_idx_i,
    output logic [PW-1:0]      rd_data_o,
    output logic [NPOT*PW-1:0] pos_flat_o
);

    localparam logic [PW-1:0] MID = PW'(1 << (PW - 1));

    logic [PW-1:0] pos_q [NPOT];

    for (genvar i = 0; i < NPOT; i++) begin : g_pot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pos_q[i] <= MID;
            end else if (wr_en_i && (wr_idx_i == IDXW'(i))) begin
                pos_q[i] <= wr_data_i;
            end
        end

        assign pos_flat_o[i*PW +: PW] = pos_q[i];

        // R1: every register leaves reset at mid-scale
        p_reset_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (pos_q[i] == MID));

        // R2: a register not addressed by a commit keeps its value
        p_only_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en_i && (wr_idx_i == IDXW'(i))) |=> $stable(pos_q[i]));
    end

    assign rd_data_o = pos_q[rd_idx_i];

endmodule

// File: rtl/qwp_core.sv
module qwp_core
    import qwp_pkg::*;
#(
    parameter int NPOT = 4,
    parameter int PW   = 6,
    localparam int IDXW = $clog2(NPOT),
    localparam int WORD = IDXW + PW,
    localparam int CW   = $clog2(WORD + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_s_i,
    input  logic            en_rise_i,
    input  logic            en_fall_i,
    input  logic            sclk_rise_i,
    input  logic            sclk_fall_i,
    input  logic            din_s_i,
    input  logic            rw_s_i,
    input  logic            din_raw_i,
    input  logic [PW-1:0]   rd_data_i,
    output logic [IDXW-1:0] rd_idx_o,
    output logic            wr_en_o,
    output logic [IDXW-1:0] wr_idx_o,
    output logic [PW-1:0]   wr_data_o,
    output logic            dout_o
);

    port_state_e   state_q, state_d;
    logic [WORD-1:0] shreg_q;
    logic [CW-1:0]   cnt_q;
    logic [IDXW-1:0] ptr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en_rise_i) state_d = rw_s_i ? ST_READ : ST_WRITE;
            ST_WRITE: if (en_fall_i) state_d = ST_IDLE;
            ST_READ:  if (en_fall_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // shift register, bit counter and readback pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            ptr_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (en_rise_i) begin
                        shreg_q <= rw_s_i ? {IDXW'(0), rd_data_i} : '0;
                        ptr_q   <= IDXW'(1);
                    end
                end
                ST_WRITE: begin
                    if (en_fall_i) begin
                        cnt_q <= '0;
                    end else if (sclk_rise_i && (cnt_q < CW'(WORD))) begin
                        shreg_q <= {shreg_q[WORD-2:0], din_s_i};
                        cnt_q   <= cnt_q + CW'(1);
                    end else if (sclk_fall_i && (cnt_q == CW'(WORD))) begin
                        cnt_q <= '0;
                    end
                end
                ST_READ: begin
                    if (en_fall_i) begin
                        cnt_q <= '0;
                    end else if (sclk_fall_i) begin
                        if (cnt_q == CW'(WORD - 1)) begin
                            shreg_q <= {ptr_q, rd_data_i};
                            ptr_q   <= ptr_q + IDXW'(1);
                            cnt_q   <= '0;
                        end else begin
                            shreg_q <= {shreg_q[WORD-2:0], 1'b0};
                            cnt_q   <= cnt_q + CW'(1);
                        end
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en_o   = 1'b0;
        wr_idx_o  = shreg_q[WORD-1 -: IDXW];
        wr_data_o = shreg_q[PW-1:0];
        rd_idx_o  = (state_q == ST_IDLE) ? '0 : ptr_q;
        dout_o    = din_raw_i;
        unique case (state_q)
            ST_IDLE:  dout_o = din_raw_i;
            ST_WRITE: begin
                dout_o  = 1'b0;
                wr_en_o = !en_fall_i && sclk_fall_i && (cnt_q == CW'(WORD));
            end
            ST_READ:  dout_o = shreg_q[WORD-1];
            default:  dout_o = 1'b0;
        endcase
    end

    // R4: a write transaction can only end in idle, never switch to read
    p_mode_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE) |=> (state_q inside {ST_WRITE, ST_IDLE}));

    // R3: a commit only happens while the port enable is still high
    p_commit_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> en_s_i);

    // R6: the bit counter never overruns a word
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(WORD));

    // R6: returning to idle always clears the bit counter
    p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (cnt_q == '0));

endmodule

// File: rtl/quad_wiper_port.sv
module quad_wiper_port (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_en_i,
    input  logic        port_clk_i,
    input  logic        port_din_i,
    input  logic        port_rd_i,
    output logic        port_dout_o,
    output logic [23:0] wiper_o,
    output logic        load_stb_o,
    output logic [1:0]  load_idx_o
);

    localparam int NPOT   = 4;
    localparam int PW     = 6;
    localparam int STAGES = 2;
    localparam int IDXW   = $clog2(NPOT);

    logic [3:0] raw_in, sync_in;
    logic       en_s, sclk_s, din_s, rw_s;
    logic       en_d_q, sclk_d_q;
    logic       en_rise, en_fall, sclk_rise, sclk_fall;

    logic [IDXW-1:0] rd_idx, wr_idx;
    logic [PW-1:0]   rd_data, wr_data;
    logic            wr_en;

    assign raw_in = {port_rd_i, port_din_i, port_clk_i, port_en_i};

    qwp_sync #(.WIDTH(4), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    assign {rw_s, din_s, sclk_s, en_s} = sync_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_d_q   <= 1'b0;
            sclk_d_q <= 1'b0;
        end else begin
            en_d_q   <= en_s;
            sclk_d_q <= sclk_s;
        end
    end

    assign en_rise   = en_s & ~en_d_q;
    assign en_fall   = ~en_s & en_d_q;
    assign sclk_rise = sclk_s & ~sclk_d_q;
    assign sclk_fall = ~sclk_s & sclk_d_q;

    qwp_core #(.NPOT(NPOT), .PW(PW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_s_i      (en_s),
        .en_rise_i   (en_rise),
        .en_fall_i   (en_fall),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .din_s_i     (din_s),
        .rw_s_i      (rw_s),
        .din_raw_i   (port_din_i),
        .rd_data_i   (rd_data),
        .rd_idx_o    (rd_idx),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .wr_data_o   (wr_data),
        .dout_o      (port_dout_o)
    );

    qwp_bank #(.NPOT(NPOT), .PW(PW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (wr_data),
        .rd_idx_i   (rd_idx),
        .rd_data_o  (rd_data),
        .pos_flat_o (wiper_o)
    );

    assign load_stb_o = wr_en;
    assign load_idx_o = wr_idx;

    // R11: the load strobe never stays high for two cycles in a row
    p_stb_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb_o |=> !load_stb_o);

endmodule

// File: tb/quad_wiper_port_test.sv
`timescale 1ns/1ps
module quad_wiper_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en_i = 1'b0, port_clk_i = 1'b0, port_din_i = 1'b0, port_rd_i = 1'b0;
    logic        port_dout_o;
    logic [23:0] wiper_o;
    logic        load_stb_o;
    logic [1:0]  load_idx_o;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    logic [1:0] last_idx = '0;
    logic [5:0] exp_pos [4];

    always #2.5 clk = ~clk;

    quad_wiper_port uut (
        .clk(clk), .rst_n(rst_n), .port_en_i(port_en_i), .port_clk_i(port_clk_i),
        .port_din_i(port_din_i), .port_rd_i(port_rd_i), .port_dout_o(port_dout_o),
        .wiper_o(wiper_o), .load_stb_o(load_stb_o), .load_idx_o(load_idx_o)
    );

    always @(posedge clk) begin
        if (load_stb_o) begin
            stb_cnt  <= stb_cnt + 1;
            last_idx <= load_idx_o;
        end
    end

    localparam int NVEC = 8;
    localparam logic [7:0] VEC [NVEC] = '{
        8'h0A, 8'h7F, 8'h80, 8'hD5, 8'h01, 8'h3F, 8'h62, 8'hC0
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int p = 0; p < 4; p++) chk(req, 32'(wiper_o[p*6 +: 6]), 32'(exp_pos[p]));
    endtask

    task automatic open_port(input logic rd);
        port_rd_i = rd;
        tick(3);
        port_en_i = 1'b1;
        tick(6);
    endtask

    task automatic close_port();
        port_en_i = 1'b0;
        tick(6);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            port_din_i = b[i];
            tick(2);
            port_clk_i = 1'b1;
            tick(4);
            port_clk_i = 1'b0;
            tick(4);
        end
    endtask

    task automatic read_word(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            b[i] = port_dout_o;
            port_clk_i = 1'b1;
            tick(4);
            port_clk_i = 1'b0;
            tick(4);
        end
    endtask

    task automatic write_one(input logic [7:0] b);
        open_port(1'b0);
        send_bits(b, 8);
        close_port();
        exp_pos[b[7:6]] = b[5:0];
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rb;
        int s0;
        for (int p = 0; p < 4; p++) exp_pos[p] = 6'd32;
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // R1: reset value
        chk_all("R1");

        // R7: idle pass-through
        port_din_i = 1'b1; #1; chk("R7", 32'(port_dout_o), 32'd1);
        port_din_i = 1'b0; #1; chk("R7", 32'(port_dout_o), 32'd0);

        // R2 + R11: table of single-word writes
        for (int v = 0; v < NVEC; v++) begin
            s0 = stb_cnt;
            write_one(VEC[v]);
            chk_all("R2");
            chk("R11 count", 32'(stb_cnt - s0), 32'd1);
            chk("R11 idx", 32'(last_idx), 32'(VEC[v][7:6]));
        end

        // R3: no commit before the falling edge of pulse eight
        open_port(1'b0);
        send_bits(8'h55, 7);
        port_din_i = 1'b1;
        tick(2);
        port_clk_i = 1'b1;
        tick(4);
        chk("R3 before", 32'(wiper_o[6 +: 6]), 32'(exp_pos[1]));
        port_clk_i = 1'b0;
        tick(4);
        chk("R3 after", 32'(wiper_o[6 +: 6]), 32'h15);
        exp_pos[1] = 6'h15;
        // R8: output inhibited during write even with din high
        port_din_i = 1'b1; #1;
        chk("R8", 32'(port_dout_o), 32'd0);
        close_port();

        // R5: four words, reverse pot order, one transaction
        s0 = stb_cnt;
        open_port(1'b0);
        send_bits(8'hC0 | 8'd7, 8);
        send_bits(8'h80 | 8'd50, 8);
        send_bits(8'h40 | 8'd40, 8);
        send_bits(8'h00 | 8'd5, 8);
        close_port();
        exp_pos[3] = 6'd7; exp_pos[2] = 6'd50; exp_pos[1] = 6'd40; exp_pos[0] = 6'd5;
        chk_all("R5");
        chk("R5 R11 strobes", 32'(stb_cnt - s0), 32'd4);
        chk("R11 last idx", 32'(last_idx), 32'd0);

        // R6: partial word dropped, next transaction aligned
        s0 = stb_cnt;
        open_port(1'b0);
        send_bits(8'hFF, 5);
        close_port();
        chk_all("R6");
        chk("R6 strobes", 32'(stb_cnt - s0), 32'd0);
        write_one(8'h80 | 8'd63);
        chk_all("R6 realign");

        // R4: select toggled during write is ignored
        open_port(1'b0);
        port_rd_i = 1'b1;
        port_din_i = 1'b1; tick(4);
        chk("R4 write", 32'(port_dout_o), 32'd0);
        send_bits(8'hC0, 8);
        close_port();
        exp_pos[3] = 6'd0;
        chk_all("R4");

        // R9 + R10: readback order and wrap
        open_port(1'b1);
        read_word(rb); chk("R9 pot0", 32'(rb), 32'h05);
        read_word(rb); chk("R9 pot1", 32'(rb), 32'h68);
        port_rd_i = 1'b0; // R4: select change ignored in read
        read_word(rb); chk("R9 R4 pot2", 32'(rb), 32'hBF);
        read_word(rb); chk("R9 pot3", 32'(rb), 32'hC0);
        read_word(rb); chk("R10 wrap", 32'(rb), 32'h05);
        close_port();
        chk_all("R9 unchanged");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule